// File: doc/BRIEF.md
# Predicated Vector Element Reverse Unit

This block reorders sub-units inside the elements of a vector under a predicate. Element width is picked at run time from a 2-bit size code. Swap granularity (byte, halfword or word) is picked separately by a 2-bit operation select. For each element the predicate marks active, the order of the swap units inside that element is reversed. The bits inside each unit keep their order. Elements that are not active take their value from a prior destination vector, so the unit merges its result into existing contents.

Size/operation pairs that cannot work raise an undefined flag, and no element is written. The unit takes one request per transfer on a valid/ready input. The result sits in a single output register with a valid/ready output. A transfer happens in a cycle where both valid and ready are high. The input is ready when the output register is empty or is being drained in that same cycle, so back-pressure from the consumer reaches the producer with no extra delay.

Top module: `vec_rev_unit`

## Requirements
- R1: Element width in bits is 8 << size_code, so codes 00/01/10/11 give 8/16/32/64-bit elements. Element e occupies bits [e*W+W-1 : e*W] of the vector.
- R2: With op_sel 00 (byte reverse), each active element has its bytes in reverse order, and the bits inside each byte keep their order.
- R3: With op_sel 01 (halfword reverse), each active element has its 16-bit units in reverse order, and the bits inside each unit keep their order.
- R4: With op_sel 10 (word reverse), each active 64-bit element has its two 32-bit halves swapped, and the bits inside each half keep their order.
- R5: Predicate bit i belongs to vector byte i (bits 8i+7..8i). An element is active exactly when the predicate bit at its lowest byte is 1. Other predicate bits inside the element have no effect. Inactive elements output the matching dst_vec bits.
- R6: undef_flag is 1 and result equals dst_vec for these cases: op_sel 11; byte reverse with size 00; halfword reverse with size 00 or 01; word reverse with any size other than 11. For all other pairs undef_flag is 0.
- R7: When no element is active, result equals dst_vec whatever src_vec holds.
- R8: A request is accepted on a rising edge where in_valid and in_ready are both 1. Its result, undef_flag and out_valid=1 appear after that edge. in_ready equals (!out_valid || out_ready).
- R9: While out_valid is 1 and out_ready is 0, out_valid, result and undef_flag hold their values and in_ready is 0.
- R10: A synchronous active-high rst clears out_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can accept a request |
| size_code | input | 2 | Element size code |
| op_sel | input | 2 | 00 byte, 01 halfword, 10 word reverse, 11 reserved |
| src_vec | input | VEC_W | Source vector |
| dst_vec | input | VEC_W | Prior destination contents |
| pred | input | VEC_W/8 | Per-byte predicate |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| result | output | VEC_W | Merged result vector |
| undef_flag | output | 1 | Requested pair was illegal |

## Verification
The hardest case to reach is a stalled output with a second request already waiting at the input. That case shows whether the held result stays intact and whether the waiting request goes in on the exact edge the stall ends. The bench holds out_ready low across several cycles while a new request is presented, then releases it. A second hard case is a predicate with bits set only at non-base byte positions of each element. Random predicates seldom produce it, so it is driven as a directed pattern next to random sweeps over all sixteen size/operation pairs.

// File: rtl/vrev_pkg.sv
package vrev_pkg;
  typedef enum logic [1:0] {
    OP_BYTES  = 2'b00,
    OP_HALVES = 2'b01,
    OP_WORDS  = 2'b10,
    OP_RSVD   = 2'b11
  } rev_op_e;

  localparam int LANE_W     = 64;
  localparam int LANE_BYTES = LANE_W / 8;
  localparam int IDX_W      = $clog2(LANE_BYTES);
endpackage

// File: rtl/vrev_legal.sv
module vrev_legal
  import vrev_pkg::*;
(
  input  logic [1:0]       size_code,
  input  rev_op_e          op,
  output logic             undef,
  output logic [IDX_W-1:0] elem_mask,
  output logic [IDX_W-1:0] swap_mask
);
  logic [IDX_W-1:0] unit_mask;

  always_comb begin
    // Byte-index bits that address bytes inside one element.
    case (size_code)
      2'd0:    elem_mask = 3'b000;
      2'd1:    elem_mask = 3'b001;
      2'd2:    elem_mask = 3'b011;
      default: elem_mask = 3'b111;
    endcase
    // Byte-index bits that address bytes inside one swap unit.
    case (op)
      OP_BYTES:  unit_mask = 3'b000;
      OP_HALVES: unit_mask = 3'b001;
      OP_WORDS:  unit_mask = 3'b011;
      default:   unit_mask = 3'b000;
    endcase
    // The unit must be strictly smaller than the element.
    undef     = (op == OP_RSVD) || (size_code <= op);
    // Flipping the unit-select bits reverses the unit order.
    swap_mask = elem_mask & ~unit_mask;
  end

  // R6: a legal pair always moves at least one unit
  always_comb begin
    if (!undef) a_r6_legal_swaps: assert (swap_mask != '0);
  end
endmodule

// File: rtl/vrev_lane.sv
module vrev_lane
  import vrev_pkg::*;
(
  input  logic [LANE_W-1:0]     src_lane,
  input  logic [LANE_W-1:0]     dst_lane,
  input  logic [LANE_BYTES-1:0] pred_lane,
  input  logic [IDX_W-1:0]      elem_mask,
  input  logic [IDX_W-1:0]      swap_mask,
  input  logic                  undef,
  output logic [LANE_W-1:0]     out_lane
);
  for (genvar b = 0; b < LANE_BYTES; b++) begin : g_byte
    localparam logic [IDX_W-1:0] BIDX = IDX_W'(b);
    logic [IDX_W-1:0] src_idx;
    logic [IDX_W-1:0] base_idx;
    logic             active;
    always_comb begin
      src_idx  = BIDX ^ swap_mask;
      base_idx = BIDX & ~elem_mask;
      active   = pred_lane[base_idx] && !undef;
      out_lane[8*b +: 8] = active ? src_lane[8*src_idx +: 8] : dst_lane[8*b +: 8];
    end
  end

  // R5: byte 0 starts an element; cleared predicate keeps destination byte
  always_comb begin
    if (!pred_lane[0]) a_r5_base_inactive: assert (out_lane[7:0] == dst_lane[7:0]);
  end
  // R6: illegal pair leaves the whole lane untouched
  always_comb begin
    if (undef) a_r6_undef_keeps_dst: assert (out_lane == dst_lane);
  end
endmodule

// File: rtl/vrev_outreg.sv
module vrev_outreg #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_undef,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] q_result,
  output logic              q_undef
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      q_result <= d_result;
      q_undef  <= d_undef;
    end
  end

  // R8: an accepted request always shows up on the output
  a_r8_accept_shows: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);
  // R9: a stalled result stays put
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(q_result) && $stable(q_undef)));
  // R10: reset empties the register
  a_r10_reset_clear: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

// File: rtl/vec_rev_unit.sv
module vec_rev_unit
  import vrev_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         size_code,
  input  logic [1:0]         op_sel,
  input  logic [VEC_W-1:0]   src_vec,
  input  logic [VEC_W-1:0]   dst_vec,
  input  logic [VEC_W/8-1:0] pred,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [VEC_W-1:0]   result,
  output logic               undef_flag
);
  localparam int NLANES = VEC_W / LANE_W;

  logic             undef_c;
  logic [IDX_W-1:0] elem_mask;
  logic [IDX_W-1:0] swap_mask;
  logic [VEC_W-1:0] merged;

  vrev_legal u_legal (
    .size_code (size_code),
    .op        (rev_op_e'(op_sel)),
    .undef     (undef_c),
    .elem_mask (elem_mask),
    .swap_mask (swap_mask)
  );

  // Elements never exceed 64 bits, so each lane is independent.
  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    vrev_lane u_lane (
      .src_lane  (src_vec[l*LANE_W +: LANE_W]),
      .dst_lane  (dst_vec[l*LANE_W +: LANE_W]),
      .pred_lane (pred[l*LANE_BYTES +: LANE_BYTES]),
      .elem_mask (elem_mask),
      .swap_mask (swap_mask),
      .undef     (undef_c),
      .out_lane  (merged[l*LANE_W +: LANE_W])
    );
  end

  vrev_outreg #(.DATA_W(VEC_W)) u_outreg (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d_result  (merged),
    .d_undef   (undef_c),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q_result  (result),
    .q_undef   (undef_flag)
  );

  // R7: an all-clear predicate gives back the destination
  always_comb begin
    if (pred == '0) a_r7_none_active: assert (merged == dst_vec);
  end
  // R9: input is blocked while a result is stalled
  a_r9_no_ready_stalled: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/test_vec_rev_unit.sv
module test_vec_rev_unit;
  localparam int VW = 128;
  localparam int PW = VW / 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic          in_ready;
  logic [1:0]    size_code;
  logic [1:0]    op_sel;
  logic [VW-1:0] src_vec;
  logic [VW-1:0] dst_vec;
  logic [PW-1:0] pred;
  logic          out_valid;
  logic          out_ready;
  logic [VW-1:0] result;
  logic          undef_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  vec_rev_unit #(.VEC_W(VW)) i_vec_rev_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .size_code(size_code), .op_sel(op_sel), .src_vec(src_vec),
    .dst_vec(dst_vec), .pred(pred), .out_valid(out_valid),
    .out_ready(out_ready), .result(result), .undef_flag(undef_flag)
  );

  function automatic logic illegal_pair(input logic [1:0] sz, input logic [1:0] op);
    case (op)
      2'b00:   return sz == 2'b00;
      2'b01:   return sz == 2'b00 || sz == 2'b01;
      2'b10:   return sz != 2'b11;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [VW-1:0] model(input logic [VW-1:0] s, input logic [VW-1:0] d,
                                          input logic [PW-1:0] p, input logic [1:0] sz,
                                          input logic [1:0] op);
    logic [VW-1:0] r;
    int eb, ub, nu;
    r = d;
    if (illegal_pair(sz, op)) return r;
    eb = 1 << sz;
    ub = 1 << op;
    nu = eb / ub;
    for (int e = 0; e < PW / eb; e++) begin
      if (p[e*eb]) begin
        for (int k = 0; k < eb; k++) begin
          r[(e*eb + k)*8 +: 8] = s[(e*eb + (nu - 1 - k/ub)*ub + k%ub)*8 +: 8];
        end
      end
    end
    return r;
  endfunction

  function automatic logic [VW-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input string req, input logic [VW-1:0] s, input logic [VW-1:0] d,
                      input logic [PW-1:0] p, input logic [1:0] sz, input logic [1:0] op);
    @(negedge clk);
    src_vec = s; dst_vec = d; pred = p; size_code = sz; op_sel = op;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R8 valid"}, VW'(out_valid), VW'(1));
    check({req, " data"}, result, model(s, d, p, sz, op));
    check({req, " R6 flag"}, VW'(undef_flag), VW'(illegal_pair(sz, op)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] a_s, a_d, b_s, b_d;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1;
    size_code = 2'd0; op_sel = 2'd0; src_vec = '0; dst_vec = '0; pred = '0;
    repeat (3) @(negedge clk);
    check("R10 reset out_valid", VW'(out_valid), VW'(0));
    check("R8 ready after reset", VW'(in_ready), VW'(1));
    rst = 1'b0;

    // Directed constants on one 64-bit element per lane
    send("R2 bytes64", {64'h0, 64'h0011223344556677}, '0, '1, 2'd3, 2'd0);
    check("R2 const", result, {64'h0, 64'h7766554433221100});
    send("R3 halves64", {64'h0, 64'h0011223344556677}, '0, '1, 2'd3, 2'd1);
    check("R3 const", result, {64'h0, 64'h6677445522330011});
    send("R4 words64", {64'h0, 64'h0011223344556677}, '0, '1, 2'd3, 2'd2);
    check("R4 const", result, {64'h0, 64'h4455667700112233});
    send("R1 bytes16", {112'h0, 16'hABCD}, '0, '1, 2'd1, 2'd0);
    check("R1 const", result, {112'h0, 16'hCDAB});

    // Only non-base predicate bits set: nothing written
    a_s = rnd_vec(); a_d = rnd_vec();
    send("R5 nonbase", a_s, a_d, 16'hFEFE, 2'd3, 2'd0);
    check("R5 nonbase keeps dst", result, a_d);
    // No active element
    a_s = rnd_vec(); a_d = rnd_vec();
    send("R7 none", a_s, a_d, '0, 2'd2, 2'd1);
    check("R7 none keeps dst", result, a_d);
    // Reserved op with full predicate
    a_s = rnd_vec(); a_d = rnd_vec();
    send("R6 rsvd", a_s, a_d, '1, 2'd3, 2'd3);
    check("R6 rsvd keeps dst", result, a_d);

    // Random sweep over every size/op pair
    for (int sz = 0; sz < 4; sz++) begin
      for (int op = 0; op < 4; op++) begin
        for (int it = 0; it < 6; it++) begin
          send("R1-sweep R2 R3 R4 R5", rnd_vec(), rnd_vec(), PW'($urandom), 2'(sz), 2'(op));
        end
      end
    end

    // Back-pressure: hold A, present B
    a_s = rnd_vec(); a_d = rnd_vec(); b_s = rnd_vec(); b_d = rnd_vec();
    @(negedge clk);
    out_ready = 1'b0;
    src_vec = a_s; dst_vec = a_d; pred = '1; size_code = 2'd2; op_sel = 2'd0;
    in_valid = 1'b1;
    @(negedge clk);
    src_vec = b_s; dst_vec = b_d; size_code = 2'd3; op_sel = 2'd1;
    check("R9 ready low in stall", VW'(in_ready), VW'(0));
    repeat (3) @(negedge clk);
    check("R9 held valid", VW'(out_valid), VW'(1));
    check("R9 held data", result, model(a_s, a_d, '1, 2'd2, 2'd0));
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 B accepted at release", result, model(b_s, b_d, '1, 2'd3, 2'd1));
    @(negedge clk);
    check("R8 drains", VW'(out_valid), VW'(0));

    // Reset while a result is stalled
    out_ready = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R10 reset clears held", VW'(out_valid), VW'(0));
    rst = 1'b0;
    out_ready = 1'b1;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule